// File: doc/BRIEF.md
# Idle Power-Save Sequencer

This block stops and restarts the clock of a processor core around an idle period. A decoded power-save instruction strobe starts entry. The block then spends exactly one transition cycle before the core clock enable drops. During that cycle it pulses a clear to the watchdog counter. The system clock, and with it every peripheral, keeps running throughout. Only the core clock enable is gated.

While idle, the block watches three wake sources: an enabled interrupt that is pending, a device reset request, and a watchdog time-out. When any of them appears, the block raises the clock enable again and gives a one-cycle wake pulse. With that pulse it reports which source won, and whether the core should fetch from the interrupt handler or go on at the instruction after the power-save instruction.

A wake event can arrive in the same cycle as the strobe, or during the transition cycle. Such an event is remembered and does not abort the entry. The core still reaches idle, and then wakes after the shortest possible idle stay.

Top module: `idle_psv_seq`

## Requirements
- R1: After reset, cpu_clk_en_o is 1, wdt_clr_o is 0, wake_o is 0, resume_isr_o is 0 and wake_cause_o is 2'b10.
- R2: A psave_req_i pulse seen in the run state leads to exactly one entry cycle. In that cycle wdt_clr_o is 1 and cpu_clk_en_o is still 1. In the cycle after it, cpu_clk_en_o is 0.
- R3: While idle with no wake source present or remembered, cpu_clk_en_o stays 0 and wake_o stays 0.
- R4: A wake source (irq_pend_i, wdt_timeout_i or dev_rst_i) seen in an idle cycle leads to a single wake cycle on the next clock. In that cycle wake_o is 1 and cpu_clk_en_o is 1. The block is back in the run state one cycle later.
- R5: wake_cause_o encodes the source of the last wake: 2'b00 interrupt, 2'b01 watchdog time-out, 2'b10 device reset. The value is held until the next wake.
- R6: When wake sources coincide, a device reset beats a watchdog time-out, which beats an interrupt.
- R7: A wake source seen in the strobe cycle or in the entry cycle is remembered, even if it then goes away. The core still enters idle for one cycle, and then wakes with that source as the cause.
- R8: resume_isr_o is 1 only in a wake cycle whose cause is an interrupt (handler entry). Otherwise it is 0, and execution goes on at the next instruction.
- R9: psave_req_i is ignored in the entry, idle and wake states.
- R10: In the run state without a strobe, wake sources have no effect: no wake pulse, no change of wake_cause_o, and nothing is remembered for a later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, never gated |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psave_req_i | input | 1 | Decoded power-save instruction strobe |
| irq_pend_i | input | 1 | An individually enabled interrupt is pending |
| wdt_timeout_i | input | 1 | Watchdog time-out event |
| dev_rst_i | input | 1 | Device reset request as a wake source |
| cpu_clk_en_o | output | 1 | Core clock enable, low only while idle |
| wdt_clr_o | output | 1 | One-cycle watchdog clear on idle entry |
| wake_o | output | 1 | One-cycle wake indication |
| wake_cause_o | output | 2 | Source of the last wake |
| resume_isr_o | output | 1 | Resume at interrupt handler (valid with wake_o) |

## Verification
Assertions check the following on every cycle:
- the entry cycle always leads to idle, and the watchdog clear is always followed by a gated clock;
- every wake pulse comes after a gated cycle and lasts one cycle;
- a reset request seen while gated always produces a reset-cause wake;
- an event seen during entry is always remembered.

Only the bench scenarios can show the exact cause encodings under coinciding sources, and the remembered-event path when the source has already gone away. The same holds for requests ignored in non-run states and for sources ignored in the run state. All of these need a chosen sequence and a known expected value.

// File: rtl/idle_psv_pkg.sv
package idle_psv_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_IDLE  = 2'd2,
    ST_WAKE  = 2'd3
  } psv_state_e;

  localparam int unsigned CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ = 2'b00,
    CAUSE_WDT = 2'b01,
    CAUSE_RST = 2'b10
  } wake_cause_e;

  localparam int unsigned NUM_SRC = 3;
  // source index order is also priority order (higher index wins)
  localparam int unsigned SRC_IRQ = 0;
  localparam int unsigned SRC_WDT = 1;
  localparam int unsigned SRC_RST = 2;
endpackage

// File: rtl/psv_event_hold.sv
module psv_event_hold #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            clear_i,
  input  logic [NSRC-1:0] ev_i,
  output logic [NSRC-1:0] held_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_hold
    logic held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  held_q <= 1'b0;
      else if (clear_i)             held_q <= 1'b0;
      else if (capture_i && ev_i[g]) held_q <= 1'b1;
    end
    assign held_o[g] = held_q;

    // R7
    held_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (capture_i && ev_i[g] && !clear_i) |=> held_o[g]);
  end
endmodule

// File: rtl/psv_cause_arb.sv
module psv_cause_arb
  import idle_psv_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSRC-1:0]    ev_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [NSRC-1:0] grant;

  always_comb begin
    grant = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ev_i[i] && grant == '0) grant[i] = 1'b1;
    end
  end

  always_comb begin
    cause_o = CAUSE_IRQ;
    if (grant[SRC_RST])      cause_o = CAUSE_RST;
    else if (grant[SRC_WDT]) cause_o = CAUSE_WDT;
  end

  assign any_o = |ev_i;

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_o == (grant != '0)));
endmodule

// File: rtl/psv_fsm.sv
module psv_fsm
  import idle_psv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       wake_any_i,
  output psv_state_e state_o
);
  psv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (req_i) state_d = ST_ENTER;
      ST_ENTER: state_d = ST_IDLE;
      ST_IDLE:  if (wake_any_i) state_d = ST_WAKE;
      ST_WAKE:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  enter_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER) |=> (state_q == ST_IDLE));
  // R9
  req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN));
endmodule

// File: rtl/idle_psv_seq.sv
module idle_psv_seq
  import idle_psv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       psave_req_i,
  input  logic       irq_pend_i,
  input  logic       wdt_timeout_i,
  input  logic       dev_rst_i,
  output logic       cpu_clk_en_o,
  output logic       wdt_clr_o,
  output logic       wake_o,
  output logic [1:0] wake_cause_o,
  output logic       resume_isr_o
);
  psv_state_e          state;
  logic [NUM_SRC-1:0]  ev_now, ev_held, ev_all;
  logic                capture, clear, wake_any;
  logic [CAUSE_W-1:0]  arb_cause;
  logic [CAUSE_W-1:0]  cause_q;

  always_comb begin
    ev_now          = '0;
    ev_now[SRC_IRQ] = irq_pend_i;
    ev_now[SRC_WDT] = wdt_timeout_i;
    ev_now[SRC_RST] = dev_rst_i;
  end

  // events coinciding with the strobe or the entry cycle are deferred
  assign capture = ((state == ST_RUN) && psave_req_i) || (state == ST_ENTER);
  assign clear   = (state == ST_WAKE);
  assign ev_all  = ev_now | ev_held;

  psv_event_hold #(.NSRC(NUM_SRC)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .clear_i   (clear),
    .ev_i      (ev_now),
    .held_o    (ev_held)
  );

  psv_cause_arb #(.NSRC(NUM_SRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_all),
    .any_o   (wake_any),
    .cause_o (arb_cause)
  );

  psv_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (psave_req_i),
    .wake_any_i (wake_any),
    .state_o    (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cause_q <= CAUSE_RST;
    else if ((state == ST_IDLE) && wake_any) cause_q <= arb_cause;
  end

  assign cpu_clk_en_o = (state != ST_IDLE);
  assign wdt_clr_o    = (state == ST_ENTER);
  assign wake_o       = (state == ST_WAKE);
  assign wake_cause_o = cause_q;
  assign resume_isr_o = wake_o && (cause_q == CAUSE_IRQ);

  // R2
  clr_then_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !cpu_clk_en_o);
  // R3
  wake_after_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(!cpu_clk_en_o));
  // R4
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> (cpu_clk_en_o && !wake_o && !wdt_clr_o));
  // R6
  rst_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && dev_rst_i) |=> (wake_o && wake_cause_o == 2'b10));
  // R5
  cause_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !wake_o) |=> $stable(wake_cause_o) || wake_o);
endmodule

// File: tb/sim_idle_psv_seq.sv
`timescale 1ns/1ps
module sim_idle_psv_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       psave_req_i = 1'b0;
  logic       irq_pend_i = 1'b0;
  logic       wdt_timeout_i = 1'b0;
  logic       dev_rst_i = 1'b0;
  logic       cpu_clk_en_o, wdt_clr_o, wake_o, resume_isr_o;
  logic [1:0] wake_cause_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  idle_psv_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .psave_req_i(psave_req_i),
    .irq_pend_i(irq_pend_i), .wdt_timeout_i(wdt_timeout_i), .dev_rst_i(dev_rst_i),
    .cpu_clk_en_o(cpu_clk_en_o), .wdt_clr_o(wdt_clr_o), .wake_o(wake_o),
    .wake_cause_o(wake_cause_o), .resume_isr_o(resume_isr_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk_i);
  endtask

  // drives strobe, samples the entry cycle, ends at first idle sample
  task automatic enter();
    psave_req_i = 1'b1;
    step();
    psave_req_i = 1'b0;
    check("R2 wdt_clr in entry", wdt_clr_o, 1);
    check("R2 clk_en in entry", cpu_clk_en_o, 1);
    step();
    check("R2 clk_en gated", cpu_clk_en_o, 0);
    check("R2 wdt_clr single", wdt_clr_o, 0);
  endtask

  task automatic wake_with(bit irq, bit wdt, bit rst, int exp_cause, string tag);
    irq_pend_i = irq; wdt_timeout_i = wdt; dev_rst_i = rst;
    step();
    irq_pend_i = 0; wdt_timeout_i = 0; dev_rst_i = 0;
    check({tag, " R4 wake"}, wake_o, 1);
    check({tag, " R4 clk_en"}, cpu_clk_en_o, 1);
    check({tag, " R5 cause"}, wake_cause_o, exp_cause);
    check({tag, " R8 resume_isr"}, resume_isr_o, (exp_cause == 0) ? 1 : 0);
    step();
    check({tag, " R4 back to run"}, wake_o, 0);
    check({tag, " R4 run clk_en"}, cpu_clk_en_o, 1);
    check({tag, " R5 cause held"}, wake_cause_o, exp_cause);
  endtask

  task automatic t_reset();
    check("R1 clk_en", cpu_clk_en_o, 1);
    check("R1 wdt_clr", wdt_clr_o, 0);
    check("R1 wake", wake_o, 0);
    check("R1 resume_isr", resume_isr_o, 0);
    check("R1 cause", wake_cause_o, 2);
  endtask

  task automatic t_run_events();
    irq_pend_i = 1; wdt_timeout_i = 1; dev_rst_i = 1;
    step(); step();
    check("R10 no wake", wake_o, 0);
    check("R10 clk_en", cpu_clk_en_o, 1);
    check("R10 cause", wake_cause_o, 2);
    irq_pend_i = 0; wdt_timeout_i = 0; dev_rst_i = 0;
    step();
    enter();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R10 nothing remembered, R3 idle", cpu_clk_en_o, 0);
      check("R3 no wake", wake_o, 0);
    end
    wake_with(1, 0, 0, 0, "irq");
  endtask

  task automatic t_single(bit irq, bit wdt, bit rst, int exp, string tag);
    enter();
    wake_with(irq, wdt, rst, exp, tag);
  endtask

  task automatic t_held_req();
    psave_req_i = 1; irq_pend_i = 1;
    step();
    psave_req_i = 0; irq_pend_i = 0;
    check("R7 entry clr", wdt_clr_o, 1);
    step();
    check("R7 idle once", cpu_clk_en_o, 0);
    step();
    check("R7 held irq wake", wake_o, 1);
    check("R7 held irq cause", wake_cause_o, 0);
    check("R8 held irq resume", resume_isr_o, 1);
    step();
  endtask

  task automatic t_held_enter();
    psave_req_i = 1;
    step();
    psave_req_i = 0; wdt_timeout_i = 1;
    step();
    wdt_timeout_i = 0;
    check("R7 idle once", cpu_clk_en_o, 0);
    step();
    check("R7 held wdt wake", wake_o, 1);
    check("R7 held wdt cause", wake_cause_o, 1);
    check("R8 no resume on wdt", resume_isr_o, 0);
    step();
  endtask

  task automatic t_ignore_req();
    enter();
    psave_req_i = 1;
    step();
    psave_req_i = 0;
    check("R9 idle req ignored", cpu_clk_en_o, 0);
    check("R9 idle no clr", wdt_clr_o, 0);
    irq_pend_i = 1;
    step();
    irq_pend_i = 0;
    check("R9 wake", wake_o, 1);
    psave_req_i = 1;
    step();
    psave_req_i = 0;
    check("R9 wake req ignored clr", wdt_clr_o, 0);
    step();
    check("R9 still run", cpu_clk_en_o, 1);
    check("R9 still no clr", wdt_clr_o, 0);
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_run_events();
    t_single(0, 1, 0, 1, "wdt");
    t_single(0, 0, 1, 2, "rst");
    t_single(1, 1, 1, 2, "R6 all");
    t_single(1, 1, 0, 1, "R6 wdt+irq");
    t_single(1, 0, 1, 2, "R6 rst+irq");
    t_held_req();
    t_held_enter();
    t_ignore_req();
    step();
    finish_run();
  end
endmodule